// File: doc/BRIEF.md
# Prioritized Nested Interrupt Event Controller

This block arbitrates five core interrupt levels, numbered 11 to 15, and tracks which of them are in service. It keeps three state vectors: a pending latch, an enable mask and an in-service set. Bit i of each vector stands for level 11+i. A raise command sets a pending bit. When an enabled pending level outranks the level the core is running, the controller issues a one-cycle dispatch strobe. The strobe carries the level number, that level's handler address from a small vector table, and a return address captured from the core's current program counter.

A lower level number means a higher priority. Level 15 is the base context. It is the running level whenever nothing else is in service, and it is never dispatched. A configuration register contains a self-nesting enable in bit 2. When that bit is set, a raise of the running level re-enters that level. In this case bit 0 of the captured return address is set, so the handler knows it was entered from its own level.

A return command carries the address the core will resume at. If bit 0 is set and self-nesting is on, the controller stays at the same level and issues a fresh dispatch to that address with bit 0 cleared. Otherwise the controller leaves the current level. Any enabled pending level that now outranks the new context is then dispatched.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After a synchronous active-low reset the pending, mask and in-service vectors are all zero, the self-nesting enable is 0, the current level reads 15 and no dispatch strobe is asserted.
- R2: The vector table is written by byte offset, with the entry for level L at offset (L-11)*4. A dispatch of level L (not a marked return) presents that entry as the vector.
- R3: A raise of level L in 11..15 sets pending bit L-11 on the next clock edge. A raise of any other level number changes nothing.
- R4: A pending level whose mask bit (bit L-11) is 0 stays pending and is never dispatched. Once its mask bit is set, it is dispatched like any other level.
- R5: Among enabled pending levels the lowest-numbered wins. It is dispatched only if its number is below the current level, so it preempts an in-service higher-numbered level. A pending level at or above the current level waits while self-nesting is off.
- R6: A dispatch decided from the state after clock edge k shows as a one-cycle strobe after edge k+1. At that same edge the level's in-service bit sets, its pending bit clears and the current level becomes that level.
- R7: A dispatch from a lower-priority context captures the core program counter with bit 0 forced to 0.
- R8: The self-nesting enable is bit 2 of the configuration write data. When it is set, an enabled pending raise of the current level re-dispatches that level with bit 0 of the captured return address set, and the in-service vector does not change. When it is clear, such a raise stays pending.
- R9: A return whose address has bit 0 set, while self-nesting is on and a level is in service, leaves the in-service vector unchanged. After the next edge it gives a strobe at the current level with vector = address with bit 0 cleared, and captured return = the address as given.
- R10: Any other return while a level is in service clears the current level's in-service bit and gives no strobe that cycle. A pending enabled level that now outranks the new current level is dispatched after the following edge.
- R11: Level 15 is never dispatched even when pending and enabled, and a return while nothing is in service changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vec_wr_en | input | 1 | Vector table write strobe |
| vec_wr_off | input | 5 | Byte offset of the table entry |
| vec_wr_data | input | 32 | Handler address to store |
| mask_wr_en | input | 1 | Mask write strobe |
| mask_wr_data | input | 5 | New enable mask, bit i = level 11+i |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 8 | Configuration value, bit 2 = self-nesting enable |
| raise_en | input | 1 | Software raise strobe |
| raise_lvl | input | 4 | Level number to raise |
| core_pc | input | 32 | Core program counter to capture on dispatch |
| rti_en | input | 1 | Return-from-interrupt strobe |
| rti_addr | input | 32 | Return address presented with the return |
| disp_vld | output | 1 | One-cycle dispatch strobe |
| disp_lvl | output | 4 | Level being entered |
| disp_vec | output | 32 | Address the core jumps to |
| disp_ret | output | 32 | Captured return address |
| pend_q | output | 5 | Pending vector readback |
| mask_q | output | 5 | Enable mask readback |
| insvc_q | output | 5 | In-service vector readback |
| nest_en_q | output | 1 | Self-nesting enable readback |
| cur_lvl | output | 4 | Current running level (15 when idle) |

## Verification
The bench builds the block with its default parameters: five levels starting at 11, 32-bit addresses and the nesting enable in configuration bit 2. With these values the whole level range is reachable, including the base level 15 at table offset 16 and an out-of-range raise of level 9. A masked middle level (12) sits between enabled ones, which makes the priority order around a masked level observable. The bench also builds a two-deep stack of distinct levels, and it exercises self re-entry through both a repeated raise and a marked return.

// File: rtl/irq_nest_pkg.sv
// Package irq_nest_pkg
// Shared types for the nested interrupt controller.
// Assumes: one event kind is chosen per cycle by the top module.
package irq_nest_pkg;

    // What the controller does in a given cycle
    typedef enum logic [1:0] {
        EV_IDLE     = 2'd0,  // nothing happens to in-service state
        EV_DISPATCH = 2'd1,  // a pending level is entered
        EV_REENTER  = 2'd2,  // marked return re-enters the same level
        EV_POP      = 2'd3   // return leaves the current level
    } nest_ev_e;

endpackage

// File: rtl/irq_lsb_pick.sv
// Module irq_lsb_pick
// Finds the lowest-indexed set bit of a request vector, i.e. the
// highest-priority level, since a lower number outranks a higher one.
// Assumes: purely combinational; idx is zero when any_set is low.
module irq_lsb_pick #(
    parameter  int N  = 5,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any_set,
    output logic [IW-1:0] idx
);

    logic [N-1:0] none_below;
    logic [N-1:0] grant;

    assign none_below[0] = 1'b1;

    // Ripple chain: bit i is granted only if no lower bit requests
    for (genvar gi = 1; gi < N; gi++) begin : g_chain
        assign none_below[gi] = none_below[gi-1] & ~req[gi-1];
    end

    assign grant   = req & none_below;
    assign any_set = |req;

    // Encode the single granted bit into an index
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = idx | IW'(i);
        end
    end

endmodule

// File: rtl/irq_vec_tbl.sv
// Module irq_vec_tbl
// Holds one handler address per level, written by byte offset with
// four-byte spacing (entry = offset / 4), read by level index.
// Assumes: low two offset bits are ignored; entries past the level
// count are dropped; synchronous active-low reset clears all entries.
module irq_vec_tbl #(
    parameter  int NLVL = 5,
    parameter  int AW   = 32,
    localparam int IW   = (NLVL > 1) ? $clog2(NLVL) : 1,
    localparam int OFFW = IW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [OFFW-1:0] wr_off,
    input  logic [AW-1:0]   wr_data,
    input  logic [IW-1:0]   rd_idx,
    output logic [AW-1:0]   rd_data
);

    logic [IW-1:0] wr_idx;
    logic [AW-1:0] entry [NLVL];

    assign wr_idx = wr_off[OFFW-1:2];

    // One register per table entry
    for (genvar gi = 0; gi < NLVL; gi++) begin : g_ent
        // Store the address when its slot is addressed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry[gi] <= '0;
            end else if (wr_en && (wr_idx == IW'(gi))) begin
                entry[gi] <= wr_data;
            end
        end
    end

    // Read mux by level index
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (rd_idx == IW'(i)) rd_data = entry[i];
        end
    end

endmodule

// File: rtl/irq_nest_ctrl.sv
// Module irq_nest_ctrl
// Prioritized nested interrupt controller for levels LVL_BASE up to
// LVL_BASE+NLVL-1. The top level number is the base context: it is
// current whenever nothing else is in service and is never entered.
// Keeps pending, mask and in-service vectors, arbitrates by lowest
// level number and handles self-nesting through bit 0 of return
// addresses. Assumes: one raise and one return per cycle at most; a
// return takes the cycle, so no dispatch is decided in the same cycle.
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter  int NLVL     = 5,
    parameter  int LVL_BASE = 11,
    parameter  int AW       = 32,
    parameter  int CFG_W    = 8,
    parameter  int NEST_BIT = 2,
    localparam int LW       = $clog2(LVL_BASE + NLVL),
    localparam int IW       = (NLVL > 1) ? $clog2(NLVL) : 1,
    localparam int OFFW     = IW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vec_wr_en,
    input  logic [OFFW-1:0]  vec_wr_off,
    input  logic [AW-1:0]    vec_wr_data,
    input  logic             mask_wr_en,
    input  logic [NLVL-1:0]  mask_wr_data,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wr_data,
    input  logic             raise_en,
    input  logic [LW-1:0]    raise_lvl,
    input  logic [AW-1:0]    core_pc,
    input  logic             rti_en,
    input  logic [AW-1:0]    rti_addr,
    output logic             disp_vld,
    output logic [LW-1:0]    disp_lvl,
    output logic [AW-1:0]    disp_vec,
    output logic [AW-1:0]    disp_ret,
    output logic [NLVL-1:0]  pend_q,
    output logic [NLVL-1:0]  mask_q,
    output logic [NLVL-1:0]  insvc_q,
    output logic             nest_en_q,
    output logic [LW-1:0]    cur_lvl
);

    localparam logic [IW-1:0] BASE_IDX = IW'(NLVL - 1);

    logic [NLVL-1:0] cand;
    logic [NLVL-1:0] raise_hit;
    logic [NLVL-1:0] pend_nxt;
    logic [NLVL-1:0] insvc_nxt;
    logic            win_any;
    logic [IW-1:0]   win_idx;
    logic            busy;
    logic [IW-1:0]   busy_idx;
    logic [IW-1:0]   cur_idx;
    logic            self_ok;
    logic            arb_go;
    logic [AW-1:0]   tbl_vec;
    logic [IW-1:0]   disp_idx_q;
    logic            disp_arb_q;
    nest_ev_e        ev;

    assign cand = pend_q & mask_q;

    // Winner among enabled pending levels
    irq_lsb_pick #(.N(NLVL)) u_pick_win (
        .req     (cand),
        .any_set (win_any),
        .idx     (win_idx)
    );

    // Innermost (highest-priority) level in service
    irq_lsb_pick #(.N(NLVL)) u_pick_cur (
        .req     (insvc_q),
        .any_set (busy),
        .idx     (busy_idx)
    );

    irq_vec_tbl #(.NLVL(NLVL), .AW(AW)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (vec_wr_en),
        .wr_off  (vec_wr_off),
        .wr_data (vec_wr_data),
        .rd_idx  (win_idx),
        .rd_data (tbl_vec)
    );

    assign cur_idx  = busy ? busy_idx : BASE_IDX;
    assign cur_lvl  = LW'(LVL_BASE) + LW'(cur_idx);
    assign disp_lvl = LW'(LVL_BASE) + LW'(disp_idx_q);

    // Decode a raise command into a one-bit-per-level set vector
    for (genvar gi = 0; gi < NLVL; gi++) begin : g_raise
        assign raise_hit[gi] = raise_en && (raise_lvl == LW'(LVL_BASE + gi));
    end

    // Same-level re-entry is allowed only for a real in-service level
    assign self_ok = nest_en_q && busy && (win_idx == cur_idx);
    assign arb_go  = win_any && ((win_idx < cur_idx) || self_ok);

    // Choose this cycle's event: a return always takes precedence
    always_comb begin
        ev = EV_IDLE;
        if (rti_en) begin
            if (busy && nest_en_q && rti_addr[0]) ev = EV_REENTER;
            else if (busy)                         ev = EV_POP;
        end else if (arb_go) begin
            ev = EV_DISPATCH;
        end
    end

    // Next pending vector: clear on entry, then add the new raise
    always_comb begin
        pend_nxt = pend_q;
        if (ev == EV_DISPATCH) pend_nxt[win_idx] = 1'b0;
        pend_nxt = pend_nxt | raise_hit;
    end

    // Next in-service vector: set on entry, clear on unmarked return
    always_comb begin
        insvc_nxt = insvc_q;
        if (ev == EV_DISPATCH) insvc_nxt[win_idx] = 1'b1;
        if (ev == EV_POP)      insvc_nxt[cur_idx] = 1'b0;
    end

    // Architectural state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= '0;
            mask_q    <= '0;
            insvc_q   <= '0;
            nest_en_q <= 1'b0;
        end else begin
            pend_q  <= pend_nxt;
            insvc_q <= insvc_nxt;
            if (mask_wr_en) mask_q    <= mask_wr_data;
            if (cfg_wr_en)  nest_en_q <= cfg_wr_data[NEST_BIT];
        end
    end

    // Registered dispatch strobe with vector and captured return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_vld   <= 1'b0;
            disp_arb_q <= 1'b0;
            disp_idx_q <= '0;
            disp_vec   <= '0;
            disp_ret   <= '0;
        end else begin
            disp_vld   <= (ev == EV_DISPATCH) || (ev == EV_REENTER);
            disp_arb_q <= (ev == EV_DISPATCH);
            if (ev == EV_DISPATCH) begin
                disp_idx_q <= win_idx;
                disp_vec   <= tbl_vec;
                disp_ret   <= {core_pc[AW-1:1], self_ok};
            end else if (ev == EV_REENTER) begin
                disp_idx_q <= cur_idx;
                disp_vec   <= {rti_addr[AW-1:1], 1'b0};
                disp_ret   <= rti_addr;
            end
        end
    end

    // R6
    disp_insvc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_vld |-> insvc_q[disp_idx_q]);

    // R4
    disp_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_vld && disp_arb_q) |-> ($past(pend_q & mask_q) != '0));

    // R8
    mark_needs_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_vld && disp_ret[0]) |-> $past(nest_en_q));

    // R5
    win_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_any |-> (cand[win_idx] &&
                     ((cand & ((NLVL'(1) << win_idx) - NLVL'(1))) == '0)));

    // R9
    reenter_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rti_en && rti_addr[0] && nest_en_q && busy) |=>
            (disp_vld && disp_ret[0] && $stable(insvc_q)));

    // R10
    pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rti_en && busy && !(rti_addr[0] && nest_en_q)) |=>
            (!disp_vld && ($countones(insvc_q) + 1 == $countones($past(insvc_q)))));

    // R11
    base_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_vld |-> (disp_idx_q != BASE_IDX));

endmodule

// File: tb/tb_irq_nest_ctrl.sv
`timescale 1ns/1ps
// Directed bench for irq_nest_ctrl; each scenario task checks itself.
module tb_irq_nest_ctrl;

    localparam int NLVL = 5;
    localparam int AW   = 32;
    localparam int LW   = 4;
    localparam int OFFW = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             vec_wr_en = 1'b0;
    logic [OFFW-1:0]  vec_wr_off = '0;
    logic [AW-1:0]    vec_wr_data = '0;
    logic             mask_wr_en = 1'b0;
    logic [NLVL-1:0]  mask_wr_data = '0;
    logic             cfg_wr_en = 1'b0;
    logic [7:0]       cfg_wr_data = '0;
    logic             raise_en = 1'b0;
    logic [LW-1:0]    raise_lvl = '0;
    logic [AW-1:0]    core_pc = '0;
    logic             rti_en = 1'b0;
    logic [AW-1:0]    rti_addr = '0;
    logic             disp_vld;
    logic [LW-1:0]    disp_lvl;
    logic [AW-1:0]    disp_vec;
    logic [AW-1:0]    disp_ret;
    logic [NLVL-1:0]  pend_q;
    logic [NLVL-1:0]  mask_q;
    logic [NLVL-1:0]  insvc_q;
    logic             nest_en_q;
    logic [LW-1:0]    cur_lvl;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    irq_nest_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .vec_wr_en(vec_wr_en), .vec_wr_off(vec_wr_off), .vec_wr_data(vec_wr_data),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .raise_en(raise_en), .raise_lvl(raise_lvl), .core_pc(core_pc),
        .rti_en(rti_en), .rti_addr(rti_addr),
        .disp_vld(disp_vld), .disp_lvl(disp_lvl), .disp_vec(disp_vec),
        .disp_ret(disp_ret), .pend_q(pend_q), .mask_q(mask_q),
        .insvc_q(insvc_q), .nest_en_q(nest_en_q), .cur_lvl(cur_lvl)
    );

    always #10 clk = ~clk;

    function automatic logic [AW-1:0] vv(input int i);
        return 32'h1000_0000 + AW'(i) * 32'h40;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic raise(input int lvl);
        raise_en = 1'b1; raise_lvl = LW'(lvl);
        tick();
        raise_en = 1'b0;
    endtask

    task automatic rti(input logic [AW-1:0] a);
        rti_en = 1'b1; rti_addr = a;
        tick();
        rti_en = 1'b0;
    endtask

    task automatic wr_mask(input logic [NLVL-1:0] m);
        mask_wr_en = 1'b1; mask_wr_data = m;
        tick();
        mask_wr_en = 1'b0;
    endtask

    task automatic wr_cfg(input logic [7:0] c);
        cfg_wr_en = 1'b1; cfg_wr_data = c;
        tick();
        cfg_wr_en = 1'b0;
    endtask

    task automatic expect_disp(input string tag, input int lvl,
                               input logic [AW-1:0] vec, input logic [AW-1:0] ret);
        chk({tag, " strobe"}, 64'(disp_vld), 64'd1);
        chk({tag, " level"},  64'(disp_lvl), 64'(lvl));
        chk({tag, " vector"}, 64'(disp_vec), 64'(vec));
        chk({tag, " return"}, 64'(disp_ret), 64'(ret));
    endtask

    task automatic t_reset();
        chk("R1 pending", 64'(pend_q), 64'd0);
        chk("R1 mask",    64'(mask_q), 64'd0);
        chk("R1 insvc",   64'(insvc_q), 64'd0);
        chk("R1 nest",    64'(nest_en_q), 64'd0);
        chk("R1 cur_lvl", 64'(cur_lvl), 64'd15);
        chk("R1 strobe",  64'(disp_vld), 64'd0);
    endtask

    task automatic t_load_vectors();
        for (int i = 0; i < NLVL; i++) begin
            vec_wr_en = 1'b1; vec_wr_off = OFFW'(i * 4); vec_wr_data = vv(i);
            tick();
        end
        vec_wr_en = 1'b0;
    endtask

    task automatic t_order();
        core_pc = 32'h0000_2001;
        raise(11); raise(12); raise(13); raise(14); raise(9);
        chk("R3 pending after raises", 64'(pend_q), 64'b01111);
        chk("R4 masked no strobe", 64'(disp_vld), 64'd0);
        wr_mask(5'b01101);
        chk("R6 no strobe before decision", 64'(disp_vld), 64'd0);
        tick();
        expect_disp("R2 R7 first", 11, vv(0), 32'h0000_2000);
        chk("R6 insvc set",   64'(insvc_q), 64'b00001);
        chk("R6 pend cleared", 64'(pend_q), 64'b01110);
        chk("R6 cur_lvl",     64'(cur_lvl), 64'd11);
        tick();
        chk("R6 strobe one cycle", 64'(disp_vld), 64'd0);
        rti(32'h0000_3000);
        chk("R10 pop insvc", 64'(insvc_q), 64'd0);
        chk("R10 no strobe on pop", 64'(disp_vld), 64'd0);
        tick();
        expect_disp("R5 R10 second", 13, vv(2), 32'h0000_2000);
        rti(32'h0000_3000);
        tick();
        expect_disp("R5 third", 14, vv(3), 32'h0000_2000);
        rti(32'h0000_3000);
        tick();
        chk("R4 masked stays", 64'(disp_vld), 64'd0);
        chk("R4 pend 12 only", 64'(pend_q), 64'b00010);
        chk("R11 back to base", 64'(cur_lvl), 64'd15);
    endtask

    task automatic t_preempt();
        core_pc = 32'h0000_7777;
        wr_mask(5'b01111);
        tick();
        expect_disp("R4 unmasked runs", 12, vv(1), 32'h0000_7776);
        raise(14);
        tick();
        chk("R5 lower waits", 64'(disp_vld), 64'd0);
        chk("R5 pend 14", 64'(pend_q), 64'b01000);
        raise(11);
        tick();
        expect_disp("R5 preempt", 11, vv(0), 32'h0000_7776);
        chk("R5 two in service", 64'(insvc_q), 64'b00011);
        chk("R5 cur 11", 64'(cur_lvl), 64'd11);
        rti(32'h0000_3000);
        chk("R10 pop inner", 64'(insvc_q), 64'b00010);
        tick();
        chk("R5 14 still below 12", 64'(disp_vld), 64'd0);
        rti(32'h0000_3000);
        tick();
        expect_disp("R10 dispatch after pop", 14, vv(3), 32'h0000_7776);
        rti(32'h0000_3000);
        tick();
    endtask

    task automatic t_nest_off();
        core_pc = 32'h0000_8000;
        raise(13);
        tick();
        expect_disp("R7 enter 13", 13, vv(2), 32'h0000_8000);
        raise(13);
        tick();
        chk("R8 no self entry", 64'(disp_vld), 64'd0);
        chk("R8 stays pending", 64'(pend_q), 64'b00100);
        chk("R8 insvc same", 64'(insvc_q), 64'b00100);
        rti(32'h0000_4001);
        chk("R10 marked ignored when off", 64'(insvc_q), 64'd0);
        chk("R10 no strobe", 64'(disp_vld), 64'd0);
        tick();
        expect_disp("R7 reenter from base", 13, vv(2), 32'h0000_8000);
        rti(32'h0000_4000);
        tick();
        chk("R10 idle after", 64'(disp_vld), 64'd0);
    endtask

    task automatic t_self_nest();
        wr_cfg(8'hFB);
        chk("R8 other cfg bits", 64'(nest_en_q), 64'd0);
        wr_cfg(8'h04);
        chk("R8 cfg bit 2", 64'(nest_en_q), 64'd1);
        core_pc = 32'h0000_5000;
        raise(11);
        tick();
        expect_disp("R7 first entry", 11, vv(0), 32'h0000_5000);
        raise(11);
        tick();
        expect_disp("R8 self entry", 11, vv(0), 32'h0000_5001);
        chk("R8 insvc same", 64'(insvc_q), 64'b00001);
        raise(13);
        tick();
        chk("R5 13 waits", 64'(pend_q), 64'b00100);
        rti(32'h0000_6001);
        expect_disp("R9 marked return", 11, 32'h0000_6000, 32'h0000_6001);
        chk("R9 insvc kept", 64'(insvc_q), 64'b00001);
        tick();
        chk("R9 single strobe", 64'(disp_vld), 64'd0);
        rti(32'h0000_6000);
        chk("R10 pop 11", 64'(insvc_q), 64'd0);
        tick();
        expect_disp("R7 from base with nest on", 13, vv(2), 32'h0000_5000);
        rti(32'h0000_6000);
        tick();
        wr_cfg(8'h00);
    endtask

    task automatic t_base();
        wr_mask(5'b11111);
        raise(15);
        tick();
        tick();
        chk("R11 base not dispatched", 64'(disp_vld), 64'd0);
        chk("R11 base pending", 64'(pend_q), 64'b10000);
        rti(32'h0000_0001);
        chk("R11 idle return insvc", 64'(insvc_q), 64'd0);
        chk("R11 idle return strobe", 64'(disp_vld), 64'd0);
        chk("R11 idle return pend", 64'(pend_q), 64'b10000);
        chk("R11 cur base", 64'(cur_lvl), 64'd15);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_load_vectors();
        t_order();
        t_preempt();
        t_nest_off();
        t_self_nest();
        t_base();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule